// File: doc/BRIEF.md
# Priority GPIO Port Pin Multiplexer

This block controls an eight-pin general-purpose port. For every pin it chooses one of three roles: an ordinary digital I/O driven from the port registers, a carrier for one on-chip peripheral signal, or a connection to one of four shared analog bus lines. The choice follows a fixed priority: analog mode wins over an enabled peripheral function, and a peripheral function wins over the plain digital setup. Software sets the roles through a small write/read register bank on a simple synchronous bus.

Analog mode is switched on for two neighbouring pins at once by one enable bit. In that mode the pin's pull-up, output and direction bits are given new meanings. The pull-up bit decides whether the pin is connected at all. A two-bit code picks the line. Odd pins take the code from the output register and even pins take it from the direction register. The analog switches are not modelled here. The block only produces a one-hot control vector for each pin. The pad levels pass through a two-flop synchronizer, and the result can be read from the bank and is also given to the peripherals.

Top module: `pinmux_port`

## Requirements
- R1: After reset every register reads 0. Every pin then has pad_oe=0, pad_pu=0 and pad_out=0, and all of ana_sw is 0, so each pin is a high-impedance digital input.
- R2: Digital mode applies when the pin is in neither analog nor function mode. In that mode, with registers OUT (address 0), DIR (address 1) and PULL (address 2), pad_out[x]=OUT[x], pad_oe[x]=DIR[x] and pad_pu[x]=PULL[x].
- R3: Function mode applies when FUNC (address 4) bit x is 1 and the pin is not analog. In that mode pad_out[x]=periph_out[x], pad_oe[x]=periph_oe[x] and pad_pu[x]=PULL[x]. The fixed pin assignment is: pin 0 UART transmit, 1 UART receive, 2 USRT line 0, 3 USRT line 1, 4 32 kHz clock, 5 CPU clock, 6 PWM 0, 7 PWM 1.
- R4: Analog mode applies when ANA (address 3) bit x/2 is 1, and it overrides function and digital settings. In analog mode pad_oe[x]=0, pad_pu[x]=0 and pad_out[x]=0.
- R5: ANA bit p switches exactly pins 2p and 2p+1. No other pin changes role.
- R6: In analog mode, PULL[x]=0 leaves pin x disconnected, with all four of its switches off. PULL[x]=1 turns on exactly one switch. No pin outside analog mode has any switch on.
- R7: Line code 00 selects line 0, 01 line 1, 10 line 2 and 11 line 3. The switch for pin x and line l is ana_sw[4*x+l].
- R8: For pin x in pair p, the code is bits [2p+1:2p] with the higher bit as MSB. These bits come from OUT when x is odd and from DIR when x is even.
- R9: pin_level and the input register (address 5) show pad_in two rising clock edges after it changes. Writes to address 5 have no effect.
- R10: Writes to addresses 0 to 4 are read back unchanged, except that only the low 4 bits of ANA are kept and its upper bits read 0. Writes to addresses 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| periph_out | input | 8 | Peripheral output value per pin |
| periph_oe | input | 8 | Peripheral output enable per pin |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pad pull-up enable |
| ana_sw | output | 32 | Analog line switches, bit 4*x+l |
| pin_level | output | 8 | Synchronized pad levels for peripherals |

## Verification
The assertions check on every cycle that analog pins drive nothing and have no pull-up. They also check that each pin has at most one switch on, that a switch is on only for a connected analog pin, that a function pin follows its peripheral, and that the synchronized level trails pad_in by two edges. The bench scenarios cover the remaining behaviour: the reset values, the mapping from each code to its line, the odd/even choice of source register, the pairing of the enable bits, the register read-back, and writes that are ignored.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int ADDR_W    = 3;
  localparam int ANA_LINES = 4;
  localparam int CODE_W    = $clog2(ANA_LINES);

  typedef enum logic [ADDR_W-1:0] {
    ADR_OUT  = 3'd0,
    ADR_DIR  = 3'd1,
    ADR_PULL = 3'd2,
    ADR_ANA  = 3'd3,
    ADR_FUNC = 3'd4,
    ADR_PIN  = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    MODE_DIO  = 2'd0,
    MODE_FUNC = 2'd1,
    MODE_ANA  = 2'd2
  } pin_mode_e;

endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d;
  logic [W-1:0] sync_d;

  always_comb begin
    meta_d = d_async;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= meta_d;
      q_sync <= sync_d;
    end
  end

endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int PINS  = 8,
  localparam int PAIRS = PINS / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic [PINS-1:0]   pin_level,
  output logic [PINS-1:0]   bus_rdata,
  output logic [PINS-1:0]   out_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   pull_q,
  output logic [PAIRS-1:0]  ana_q,
  output logic [PINS-1:0]   func_q
);

  logic we_out, we_dir, we_pull, we_ana, we_func;

  always_comb begin
    we_out  = bus_we && (bus_addr == ADR_OUT);
    we_dir  = bus_we && (bus_addr == ADR_DIR);
    we_pull = bus_we && (bus_addr == ADR_PULL);
    we_ana  = bus_we && (bus_addr == ADR_ANA);
    we_func = bus_we && (bus_addr == ADR_FUNC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      ana_q  <= '0;
      func_q <= '0;
    end else begin
      if (we_out)  out_q  <= bus_wdata;
      if (we_dir)  dir_q  <= bus_wdata;
      if (we_pull) pull_q <= bus_wdata;
      if (we_ana)  ana_q  <= bus_wdata[PAIRS-1:0];
      if (we_func) func_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_OUT:  bus_rdata = out_q;
      ADR_DIR:  bus_rdata = dir_q;
      ADR_PULL: bus_rdata = pull_q;
      ADR_ANA:  bus_rdata[PAIRS-1:0] = ana_q;
      ADR_FUNC: bus_rdata = func_q;
      ADR_PIN:  bus_rdata = pin_level;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pinmux_pin_ctrl.sv
module pinmux_pin_ctrl
  import pinmux_pkg::*;
(
  input  logic                 ana_en,
  input  logic                 func_en,
  input  logic                 reg_out,
  input  logic                 reg_dir,
  input  logic                 reg_pull,
  input  logic                 periph_out,
  input  logic                 periph_oe,
  input  logic [CODE_W-1:0]    line_code,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 pad_pu,
  output logic [ANA_LINES-1:0] line_sw
);

  pin_mode_e mode;

  always_comb begin
    if (ana_en)       mode = MODE_ANA;
    else if (func_en) mode = MODE_FUNC;
    else              mode = MODE_DIO;
  end

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    pad_pu  = 1'b0;
    line_sw = '0;
    case (mode)
      MODE_ANA: begin
        line_sw[line_code] = reg_pull;
      end
      MODE_FUNC: begin
        pad_out = periph_out;
        pad_oe  = periph_oe;
        pad_pu  = reg_pull;
      end
      default: begin
        pad_out = reg_out;
        pad_oe  = reg_dir;
        pad_pu  = reg_pull;
      end
    endcase
  end

endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int PINS = 8,
  localparam int PAIRS = PINS / 2,
  localparam int SW_W  = PINS * ANA_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   periph_out,
  input  logic [PINS-1:0]   periph_oe,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pu,
  output logic [SW_W-1:0]   ana_sw,
  output logic [PINS-1:0]   pin_level
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [PINS-1:0]  out_q, dir_q, pull_q, func_q;
  logic [PAIRS-1:0] ana_q;

  pinmux_sync #(.W(PINS)) sync_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (pad_in),
    .q_sync  (pin_level)
  );

  pinmux_regs #(.PINS(PINS)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_level (pin_level),
    .bus_rdata (bus_rdata),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .pull_q    (pull_q),
    .ana_q     (ana_q),
    .func_q    (func_q)
  );

  for (genvar x = 0; x < PINS; x++) begin : g_pin
    localparam int P = x / 2;
    logic [CODE_W-1:0] code;

    // odd pins draw their line code from OUT, even pins from DIR
    if (x % 2 == 1) begin : g_odd
      assign code = out_q[2*P+1 -: 2];
    end else begin : g_even
      assign code = dir_q[2*P+1 -: 2];
    end

    pinmux_pin_ctrl ctrl_i (
      .ana_en     (ana_q[P]),
      .func_en    (func_q[x]),
      .reg_out    (out_q[x]),
      .reg_dir    (dir_q[x]),
      .reg_pull   (pull_q[x]),
      .periph_out (periph_out[x]),
      .periph_oe  (periph_oe[x]),
      .line_code  (code),
      .pad_out    (pad_out[x]),
      .pad_oe     (pad_oe[x]),
      .pad_pu     (pad_pu[x]),
      .line_sw    (ana_sw[x*ANA_LINES +: ANA_LINES])
    );
  end

endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk
  import pinmux_pkg::*;
#(
  parameter int PINS = 8,
  localparam int PAIRS = PINS / 2,
  localparam int SW_W  = PINS * ANA_LINES
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [PINS-1:0]   pad_in,
  input logic [PINS-1:0]   pin_level,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pad_pu,
  input logic [SW_W-1:0]   ana_sw,
  input logic [PAIRS-1:0]  ana_q,
  input logic [PINS-1:0]   func_q,
  input logic [PINS-1:0]   pull_q,
  input logic [PINS-1:0]   periph_out,
  input logic [PINS-1:0]   periph_oe
);

  logic [1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)        up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (up_cnt == 2'd3) |-> (pin_level == $past(pad_in, 2))); // R9

  for (genvar x = 0; x < PINS; x++) begin : g_chk
    AST_ANA_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ana_q[x/2] |-> (!pad_oe[x] && !pad_pu[x] && !pad_out[x])); // R4

    AST_SW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $onehot0(ana_sw[x*ANA_LINES +: ANA_LINES])); // R6

    AST_SW_NEEDS_CONNECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (|ana_sw[x*ANA_LINES +: ANA_LINES]) |-> (ana_q[x/2] && pull_q[x])); // R6

    AST_FUNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!ana_q[x/2] && func_q[x]) |->
        (pad_out[x] == periph_out[x] && pad_oe[x] == periph_oe[x])); // R3
  end

endmodule

bind pinmux_port pinmux_port_chk #(.PINS(PINS)) chk_i (.*);

// File: tb/pinmux_port_tb_top.sv
module pinmux_port_tb_top;

  localparam int PINS = 8;
  localparam int SW_W = PINS * 4;

  logic            clk;
  logic            rst_n;
  logic            bus_we;
  logic [2:0]      bus_addr;
  logic [PINS-1:0] bus_wdata;
  logic [PINS-1:0] bus_rdata;
  logic [PINS-1:0] periph_out;
  logic [PINS-1:0] periph_oe;
  logic [PINS-1:0] pad_in;
  logic [PINS-1:0] pad_out;
  logic [PINS-1:0] pad_oe;
  logic [PINS-1:0] pad_pu;
  logic [SW_W-1:0] ana_sw;
  logic [PINS-1:0] pin_level;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // shadow of the register contents, kept by the bench
  logic [7:0] s_out, s_dir, s_pull, s_func;
  logic [3:0] s_ana;

  pinmux_port #(.PINS(PINS)) dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      3'd0: s_out  = d;
      3'd1: s_dir  = d;
      3'd2: s_pull = d;
      3'd3: s_ana  = d[3:0];
      3'd4: s_func = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // expected outputs from the requirement rules
  task automatic check_model(input string tag);
    logic [7:0]  e_out, e_oe, e_pu;
    logic [31:0] e_sw;
    e_out = '0; e_oe = '0; e_pu = '0; e_sw = '0;
    for (int x = 0; x < PINS; x++) begin
      int p;
      logic [1:0] code;
      p = x / 2;
      if (s_ana[p]) begin
        code = (x % 2 == 1) ? s_out[2*p+1 -: 2] : s_dir[2*p+1 -: 2];
        if (s_pull[x]) e_sw[4*x + code] = 1'b1;
      end else if (s_func[x]) begin
        e_out[x] = periph_out[x]; e_oe[x] = periph_oe[x]; e_pu[x] = s_pull[x];
      end else begin
        e_out[x] = s_out[x]; e_oe[x] = s_dir[x]; e_pu[x] = s_pull[x];
      end
    end
    check({tag, " pad_out"}, {24'd0, pad_out}, {24'd0, e_out});
    check({tag, " pad_oe"},  {24'd0, pad_oe},  {24'd0, e_oe});
    check({tag, " pad_pu"},  {24'd0, pad_pu},  {24'd0, e_pu});
    check({tag, " ana_sw"},  ana_sw, e_sw);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d);
      check($sformatf("R1 reg %0d after reset", a), {24'd0, d}, 32'd0);
    end
    check("R1 pad_oe", {24'd0, pad_oe}, 32'd0);
    check("R1 pad_pu", {24'd0, pad_pu}, 32'd0);
    check("R1 ana_sw", ana_sw, 32'd0);
  endtask

  task automatic t_digital;
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h81);
    check("R2 pad_out", {24'd0, pad_out}, 32'hA5);
    check("R2 pad_oe",  {24'd0, pad_oe},  32'h3C);
    check("R2 pad_pu",  {24'd0, pad_pu},  32'h81);
    wr(3'd0, 8'h5A);
    check_model("R2 second pattern");
  endtask

  task automatic t_function;
    periph_out = 8'hC3; periph_oe = 8'h0F;
    wr(3'd4, 8'hF0);
    check_model("R3 upper pins function");
    check("R3 pad_out mix", {24'd0, pad_out}, 32'hCA);
    periph_out = 8'h3C; #1;
    check_model("R3 peripheral toggles");
    wr(3'd4, 8'h00);
  endtask

  task automatic t_analog_codes;
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd4, 8'h00);
    wr(3'd2, 8'h03);
    wr(3'd0, 8'h02);  // pin1 code 10
    wr(3'd1, 8'h01);  // pin0 code 01
    wr(3'd3, 8'h01);
    check("R7 R8 pair0 lines", ana_sw, 32'h0000_0042);
    check("R4 analog no drive", {24'd0, pad_oe[1:0], pad_pu[1:0]}, 32'd0);
    wr(3'd0, 8'hC0); wr(3'd1, 8'h80); wr(3'd2, 8'hC0); wr(3'd3, 8'h08);
    // pin7 code 11 -> bit 31, pin6 code 10 -> bit 26
    check("R7 R8 pair3 lines", ana_sw, 32'h8400_0000);
    for (int c = 0; c < 4; c++) begin
      wr(3'd0, 8'(c << 6));
      wr(3'd1, 8'(c << 6));
      check_model($sformatf("R7 code %0d", c));
    end
  endtask

  task automatic t_priority_pairs;
    periph_out = 8'hFF; periph_oe = 8'hFF;
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd4, 8'hFF);
    wr(3'd3, 8'h04);
    check("R4 R5 pair2 off", {24'd0, pad_oe}, 32'hCF);
    check("R5 pair2 only switches", ana_sw, 32'h0088_0000);
    check_model("R4 analog over function");
    wr(3'd2, 8'hDF);
    check("R6 pin5 disconnected", ana_sw, 32'h0008_0000);
    wr(3'd2, 8'h00);
    check("R6 all disconnected", ana_sw, 32'd0);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    check_model("R2 back to digital");
  endtask

  task automatic t_input;
    logic [7:0] d;
    @(negedge clk); pad_in = 8'h96;
    @(negedge clk);
    check("R9 one edge old value", {24'd0, pin_level}, 32'h00);
    @(negedge clk);
    check("R9 two edges new value", {24'd0, pin_level}, 32'h96);
    rd(3'd5, d);
    check("R9 input register", {24'd0, d}, 32'h96);
    wr(3'd5, 8'h00);
    rd(3'd5, d);
    check("R9 input write ignored", {24'd0, d}, 32'h96);
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h44); wr(3'd4, 8'h88);
    wr(3'd3, 8'hF5);
    rd(3'd3, d); check("R10 ana upper bits zero", {24'd0, d}, 32'h05);
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd0, d); check("R10 out readback", {24'd0, d}, 32'h11);
    rd(3'd1, d); check("R10 dir readback", {24'd0, d}, 32'h22);
    rd(3'd2, d); check("R10 pull readback", {24'd0, d}, 32'h44);
    rd(3'd4, d); check("R10 func readback", {24'd0, d}, 32'h88);
    rd(3'd3, d); check("R10 ana after bad addr", {24'd0, d}, 32'h05);
    check_model("R10 outputs after bad addr");
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    periph_out = '0; periph_oe = '0; pad_in = '0;
    s_out = '0; s_dir = '0; s_pull = '0; s_func = '0; s_ana = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_digital();
    t_function();
    t_analog_codes();
    t_priority_pairs();
    t_input();
    t_regmap();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule